// File: doc/BRIEF.md
# Serial Memory Slave Protocol Engine

This block is the bus-facing front end of a 512-byte serial memory split into two 256-byte banks. It watches oversampled clock and data lines from a two-wire bus, finds START and STOP conditions, and decodes the select byte. It acknowledges by pulling the data line low through an open-drain enable. It keeps a 9-bit address pointer and returns read data most significant bit first.

For reads it fetches bytes through a simple synchronous read port: a read enable with an address, and data one system clock later. It supports reading at the current pointer, random reads set up by a dummy write of the address, and sequential streams that continue while the master acknowledges. Incoming write data bytes are passed to a separate write controller as one-cycle strobes carrying data and address. A STOP at the end of a write that carried data gives a strobe that starts programming. While the write controller reports a programming cycle in progress, the engine does not answer.

The system clock must run at least eight times faster than the bus clock. Both bus lines pass through a two-flop synchronizer before edge detection.

Top module: `eepromI2cSlave`

## Requirements
- R1: After reset, sdaPullLow, memRdEn, wrByteValid and wrStop are all 0.
- R2: The select byte is acknowledged only when its bits 7..4 are 1010, bit 3 equals chipSel[1] and bit 2 equals chipSel[0]. A mismatching select gets no acknowledge, and later bytes are ignored until the next START.
- R3: An accepted byte is acknowledged by holding sdaPullLow high through the 9th SCL clock. sdaPullLow changes only while SCL is low.
- R4: In a write transfer, bit 1 of the select byte and the following byte form the pointer (bit 8 from the select, bits 7..0 from the byte). A repeated START with a read select (bit 0 = 1) then returns the byte at that pointer, MSB first.
- R5: A read select that is not preceded by an address byte reads from the pointer left by the previous transfer: one past the last byte read or written, or the loaded address if no data moved.
- R6: Each byte the master acknowledges (SDA low on the 9th clock) is followed by the byte at the next address, and the pointer wraps from 0x1FF to 0x000.
- R7: After a master no-acknowledge followed by STOP, the engine stays silent on further SCL clocks until a new START.
- R8: While busyWrite is 1, a matching select byte gets no acknowledge.
- R9: Each data byte after the address byte of a write gives one wrByteValid pulse carrying wrData and wrAddr, is acknowledged, and advances the pointer by one.
- R10: STOP after at least one write data byte gives one wrStop pulse. STOP after only a select and an address byte gives none.
- R11: Before the first START, clocked bytes get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line as seen on the wire |
| chipSel | input | 2 | Strap value matched against select bits 3..2 |
| busyWrite | input | 1 | Programming cycle in progress |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| memAddr | output | 9 | Array read address |
| memRdEn | output | 1 | Array read enable; data expected one clock later |
| memRdData | input | 8 | Array read data |
| wrByteValid | output | 1 | One-cycle strobe for a received write data byte |
| wrData | output | 8 | Write data byte, valid with wrByteValid |
| wrAddr | output | 9 | Address for wrData, valid with wrByteValid |
| wrStop | output | 1 | One-cycle strobe that starts programming |

## Verification
A wrong bit counter or a wrong control state shows up at the bus within one byte. The acknowledge appears on the wrong clock or not at all, and read data comes out shifted by a bit. A pointer fault is visible only when the data comes back: the returned value belongs to another address. That shows on the first byte of a current-address read, or on the byte after a wrap in a sequential read. Write handoff faults appear as a wrong strobe count or a wrong address on the write side, checked right after each transfer.

// File: rtl/i2cEepPkg.sv
package i2cEepPkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef struct packed {
    logic ptrLoad;   // load pointer from address byte
    logic ptrHi;     // bank bit taken from write select
    logic ptrInc;    // advance pointer
    logic fetch;     // issue array read
    logic wrValid;   // hand a data byte to write controller
    logic ackReq;    // pull SDA on the coming 9th clock
    logic txMode;    // engine transmits data bits
  } ctrlStrb_t;
endpackage

// File: rtl/i2cBusSync.sv
module i2cBusSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclD    <= sclPipe[STAGES-1];
      sdaD    <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/i2cSlvData.sv
module i2cSlvData
  import i2cEepPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  ctrlStrb_t         strb,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteDone,
  output logic              ackClk,
  output logic              masterAck,
  output logic              sdaDrv,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData,
  output logic              wrByteValid,
  output logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] wrAddr
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shReg, txShift;
  logic [ADDR_W-1:0] ptr, ptrNext;
  logic              loadTx;

  assign rxByte    = {shReg[DATA_W-2:0], sdaS};
  assign byteDone  = sclRise && (bitCnt == LAST_BIT);
  assign ackClk    = sclRise && (bitCnt == ACK_SLOT);
  assign masterAck = ~sdaS;
  assign ptrNext   = ptr + ADDR_W'(1);
  assign memAddr   = strb.ptrInc ? ptrNext : ptr;
  assign memRdEn   = strb.fetch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else if (startDet) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      if (bitCnt == ACK_SLOT) begin
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + CNT_W'(1);
        shReg  <= rxByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrLoad) begin
      ptr <= {strb.ptrHi, rxByte};
    end else if (strb.ptrInc) begin
      ptr <= ptrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadTx  <= 1'b0;
      txShift <= '1;
      sdaDrv  <= 1'b0;
    end else begin
      loadTx <= memRdEn;
      if (loadTx) begin
        txShift <= memRdData;
      end else if (sclFall) begin
        if (bitCnt == ACK_SLOT) begin
          sdaDrv <= strb.ackReq;
        end else if (strb.txMode) begin
          sdaDrv  <= ~txShift[DATA_W-1];
          txShift <= {txShift[DATA_W-2:0], 1'b1};
        end else begin
          sdaDrv <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrByteValid <= 1'b0;
      wrData      <= '0;
      wrAddr      <= '0;
    end else begin
      wrByteValid <= strb.wrValid;
      if (strb.wrValid) begin
        wrData <= rxByte;
        wrAddr <= ptr;
      end
    end
  end

  // R3: the data line is only moved while the bus clock is low
  p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrv) |-> !sclS);

  // R6: array reads are launched from a rising bus clock, never mid-low phase
  p_fetch_scl_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> sclS);

  // R9: one strobe per received data byte
  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrByteValid |=> !wrByteValid);
endmodule

// File: rtl/i2cSlvCtrl.sv
module i2cSlvCtrl
  import i2cEepPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              byteDone,
  input  logic              ackClk,
  input  logic              masterAck,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [1:0]        chipSel,
  input  logic              busyWrite,
  output ctrlStrb_t         strb,
  output logic              wrStop
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_ADDR, ST_WDATA, ST_TX, ST_HOLD
  } ctrlState_t;

  ctrlState_t state;
  logic ackReq, rwRd, a8Hold, gotData;
  logic selMatch;

  assign selMatch = (rxByte[7:4] == DEV_CODE) && (rxByte[3:2] == chipSel) && !busyWrite;

  always_comb begin
    strb         = '0;
    strb.ackReq  = ackReq;
    strb.txMode  = (state == ST_TX);
    strb.ptrHi   = a8Hold;
    if (byteDone && state == ST_ADDR) strb.ptrLoad = 1'b1;
    if (byteDone && state == ST_WDATA) begin
      strb.wrValid = 1'b1;
      strb.ptrInc  = 1'b1;
    end
    if (ackClk && state == ST_SEL && ackReq && rwRd) strb.fetch = 1'b1;
    if (ackClk && state == ST_TX) begin
      strb.ptrInc = 1'b1;
      strb.fetch  = masterAck;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackReq  <= 1'b0;
      rwRd    <= 1'b0;
      a8Hold  <= 1'b0;
      gotData <= 1'b0;
      wrStop  <= 1'b0;
    end else begin
      wrStop <= 1'b0;
      if (startDet) begin
        state   <= busyWrite ? ST_IDLE : ST_SEL;
        ackReq  <= 1'b0;
        gotData <= 1'b0;
      end else if (stopDet) begin
        if (state == ST_WDATA && gotData) wrStop <= 1'b1;
        if (state != ST_TX) begin
          state  <= ST_IDLE;
          ackReq <= 1'b0;
        end
      end else if (byteDone) begin
        case (state)
          ST_SEL: begin
            if (selMatch) begin
              ackReq <= 1'b1;
              rwRd   <= rxByte[0];
              if (!rxByte[0]) a8Hold <= rxByte[1];
            end else begin
              state <= ST_HOLD;
            end
          end
          ST_ADDR:  ackReq <= 1'b1;
          ST_WDATA: begin
            ackReq  <= 1'b1;
            gotData <= 1'b1;
          end
          default: ;
        endcase
      end else if (ackClk) begin
        ackReq <= 1'b0;
        case (state)
          ST_SEL:   state <= rwRd ? ST_TX : ST_ADDR;
          ST_ADDR:  state <= ST_WDATA;
          ST_TX:    if (!masterAck) state <= ST_HOLD;
          default: ;
        endcase
      end
    end
  end

  // R8: a select seen while programming never raises an acknowledge
  p_busy_no_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEL && byteDone && busyWrite) |=> !ackReq);

  // R10: programming start is a single pulse
  p_stop_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrStop |=> !wrStop);
endmodule

// File: rtl/eepromI2cSlave.sv
module eepromI2cSlave
  import i2cEepPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        chipSel,
  input  logic              busyWrite,
  output logic              sdaPullLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData,
  output logic              wrByteValid,
  output logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrStop
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic byteDone, ackClk, masterAck;
  logic [DATA_W-1:0] rxByte;
  ctrlStrb_t strb;

  i2cBusSync #(.STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cSlvCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .ackClk(ackClk), .masterAck(masterAck),
    .rxByte(rxByte), .chipSel(chipSel), .busyWrite(busyWrite),
    .strb(strb), .wrStop(wrStop)
  );

  i2cSlvData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .strb(strb),
    .rxByte(rxByte), .byteDone(byteDone), .ackClk(ackClk), .masterAck(masterAck),
    .sdaDrv(sdaPullLow), .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .wrByteValid(wrByteValid), .wrData(wrData), .wrAddr(wrAddr)
  );
endmodule

// File: tb/sim_eepromI2cSlave.sv
module sim_eepromI2cSlave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic masterLow = 1'b0;
  logic busy = 1'b0;
  logic sdaLine;
  logic sdaPullLow, memRdEn, wrByteValid, wrStop;
  logic [8:0] memAddr, wrAddr;
  logic [7:0] memRdData, wrData;
  int nChk = 0;
  int nFail = 0;
  int wrCnt = 0;
  int stopCnt = 0;
  logic [7:0] logD [8];
  logic [8:0] logA [8];
  logic finished = 1'b0;

  always #5 clk = ~clk;

  assign sdaLine = ~(masterLow | sdaPullLow);

  eepromI2cSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .chipSel(2'b10),
    .busyWrite(busy), .sdaPullLow(sdaPullLow), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .wrByteValid(wrByteValid), .wrData(wrData),
    .wrAddr(wrAddr), .wrStop(wrStop)
  );

  function automatic logic [7:0] fMem(input logic [8:0] a);
    int v;
    v = int'(a[7:0]) * 37 + int'(a[8]) * 91 + 5;
    return 8'(v);
  endfunction

  always @(posedge clk) begin
    if (memRdEn) memRdData <= fMem(memAddr);
    if (wrByteValid) begin
      logD[wrCnt[2:0]] <= wrData;
      logA[wrCnt[2:0]] <= wrAddr;
      wrCnt <= wrCnt + 1;
    end
    if (wrStop) stopCnt <= stopCnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    masterLow = 1'b0; tick(5);
    scl = 1'b1; tick(5);
    masterLow = 1'b1; tick(5);
    scl = 1'b0;
  endtask

  task automatic stopC();
    tick(5); masterLow = 1'b1; tick(5);
    scl = 1'b1; tick(5);
    masterLow = 1'b0; tick(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(5); masterLow = ~b[i]; tick(5);
      scl = 1'b1; tick(10); scl = 1'b0;
    end
    tick(5); masterLow = 1'b0; tick(5);
    scl = 1'b1; tick(5);
    ack = ~sdaLine; tick(5);
    scl = 1'b0;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(5); masterLow = 1'b0; tick(5);
      scl = 1'b1; tick(5);
      b[i] = sdaLine; tick(5);
      scl = 1'b0;
    end
    tick(5); masterLow = giveAck; tick(5);
    scl = 1'b1; tick(10);
    scl = 1'b0;
  endtask

  // select + address, then repeated START with read select
  task automatic seekRead(input logic [8:0] a, output logic allAck);
    logic k1, k2, k3;
    startC();
    sendByte({4'b1010, 2'b10, a[8], 1'b0}, k1);
    sendByte(a[7:0], k2);
    startC();
    sendByte({4'b1010, 2'b10, a[8], 1'b1}, k3);
    allAck = k1 & k2 & k3;
  endtask

  typedef struct packed {
    logic [7:0] sel;
    logic [7:0] addr;
    logic       expAck;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hA8, 8'h00, 1'b1},
    '{8'hAA, 8'h3C, 1'b1},
    '{8'hA8, 8'hFF, 1'b1},
    '{8'hAA, 8'hFF, 1'b1},
    '{8'hA4, 8'h10, 1'b0},
    '{8'hB8, 8'h10, 1'b0},
    '{8'h2A, 8'h10, 1'b0},
    '{8'hAC, 8'h10, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic ack, ok;
    logic [7:0] rb;
    tick(3);
    // R1: reset state
    chk("R1 outputs idle", {sdaPullLow, memRdEn, wrByteValid, wrStop}, 0);
    rstN = 1'b1;
    tick(5);
    chk("R1 outputs idle after release", {sdaPullLow, memRdEn, wrByteValid, wrStop}, 0);

    // R11: no START yet, so a matching byte is not acknowledged
    scl = 1'b0; tick(5);
    sendByte(8'hA8, ack);
    chk("R11 no ack before START", ack, 0);
    tick(5);

    // R2/R4: table of selects and addresses
    foreach (VECS[n]) begin
      startC();
      sendByte(VECS[n].sel, ack);
      chk("R2 select ack", ack, VECS[n].expAck);
      if (VECS[n].expAck) begin
        sendByte(VECS[n].addr, ack);
        chk("R3 address ack", ack, 1);
        startC();
        sendByte(VECS[n].sel | 8'h01, ack);
        chk("R4 read select ack", ack, 1);
        readByte(1'b0, rb);
        chk("R4 random read data", rb, fMem({VECS[n].sel[1], VECS[n].addr}));
      end else begin
        sendByte(VECS[n].addr, ack);
        chk("R2 ignored after mismatch", ack, 0);
      end
      stopC();
    end

    // R5: current-address read after a random read
    seekRead(9'h050, ok);
    chk("R4 seek acks", ok, 1);
    readByte(1'b0, rb);
    stopC();
    startC();
    sendByte(8'hA9, ack);
    chk("R5 current read select ack", ack, 1);
    readByte(1'b0, rb);
    chk("R5 current read data", rb, fMem(9'h051));
    stopC();

    // R6: sequential read across the 0x1FF wrap
    seekRead(9'h1FE, ok);
    readByte(1'b1, rb);
    chk("R6 seq byte 0", rb, fMem(9'h1FE));
    readByte(1'b1, rb);
    chk("R6 seq byte 1", rb, fMem(9'h1FF));
    readByte(1'b0, rb);
    chk("R6 seq wrap to 000", rb, fMem(9'h000));
    stopC();

    // R7: after no-ack and STOP, the engine stays silent
    seekRead(9'h020, ok);
    readByte(1'b1, rb);
    chk("R6 seq first", rb, fMem(9'h020));
    readByte(1'b0, rb);
    chk("R6 seq second", rb, fMem(9'h021));
    stopC();
    scl = 1'b0;
    readByte(1'b0, rb);
    chk("R7 silent after nack stop", rb, 8'hFF);
    tick(5);

    // R8: programming in progress
    busy = 1'b1;
    startC();
    sendByte(8'hA8, ack);
    chk("R8 no ack while busy", ack, 0);
    stopC();
    busy = 1'b0;

    // R9/R10: write with two data bytes
    startC();
    sendByte(8'hAA, ack);
    sendByte(8'h2A, ack);
    sendByte(8'h11, ack);
    chk("R9 data ack", ack, 1);
    sendByte(8'h22, ack);
    chk("R9 data ack 2", ack, 1);
    stopC();
    tick(4);
    chk("R9 strobe count", wrCnt, 2);
    chk("R9 first data", logD[0], 8'h11);
    chk("R9 first addr", logA[0], 9'h12A);
    chk("R9 second data", logD[1], 8'h22);
    chk("R9 second addr", logA[1], 9'h12B);
    chk("R10 stop strobe", stopCnt, 1);

    // R5: current read after write continues past last written byte
    startC();
    sendByte(8'hA9, ack);
    readByte(1'b0, rb);
    chk("R5 read after write", rb, fMem(9'h12C));
    stopC();

    // R10: address-only write gives no programming start
    startC();
    sendByte(8'hA8, ack);
    sendByte(8'h70, ack);
    stopC();
    tick(4);
    chk("R10 no stop strobe without data", stopCnt, 1);
    chk("R9 no extra strobe", wrCnt, 2);
    startC();
    sendByte(8'hA9, ack);
    readByte(1'b0, rb);
    chk("R5 read after address-only write", rb, fMem(9'h070));
    stopC();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule